// File: doc/BRIEF.md
# LCD Controller Command Decoder

This block sits behind a two-wire serial bus receiver, after the slave address has matched. It takes received bytes one at a time. The receiver marks each byte as either a command byte or a display byte. Command bytes are decoded into the display configuration:

- display enable
- bias selection
- drive mode, which sets the number of backplanes
- RAM bank selection
- blink setting
- a display data pointer
- a subaddress counter

Display bytes go out on a display RAM write port, at the address held in the data pointer. A display byte is written only when the subaddress counter equals the device's three hardware subaddress pins. This lets several identical devices share one bus and cascade through a single stream of display data.

Bytes arrive on a valid/ready stream. A byte is consumed in a cycle where `rx_valid` and `rx_ready` are both high. The bench holds `rx_data` and `rx_is_cmd` stable while `rx_valid` is high. `rx_ready` drops for one reason only: a display byte that must be written is waiting for a RAM port that has `ram_wready` low. The RAM write request is combinational from the held byte, so `ram_wvalid`, `ram_waddr` and `ram_wdata` stay stable until the write is taken.

A bus START opens a transfer and a STOP closes it. A START given while a transfer is already open simply continues access. START and STOP take effect from the cycle after they are sampled, and START wins if both are high in the same cycle. All configuration outputs come from registers and change on the clock edge that consumes the byte. `ack_en`, `ram_wvalid` and `rx_ready` are combinational from the byte being offered.

Top module: `lcdcd_top`

## Requirements
- R1: After reset the display is disabled, bias_sel is 0 and drive_mode is 00 (four backplanes, so mux_ways is 4). bias_eff, the data pointer, the subaddress counter, both bank bits and the blink fields are all 0. No transfer is open.
- R2: A command byte 1100_EBMM loads the three mode fields. Bit 3 goes to disp_en (0 blanks, 1 enables), bit 2 to bias_sel and bits 1:0 to drive_mode. mux_ways then reads 1 for drive mode 01 (static), 2 for 10, 3 for 11 and 4 for 00.
- R3: bias_eff follows bias_sel, except that it is 0 whenever drive_mode is 01 (static).
- R4: A command byte with bit 7 = 0 loads bits 6:0 into the data pointer.
- R5: A command byte 11100_AAA loads AAA into the subaddress counter.
- R6: A command byte 11110_xIO sets bank_in to I (bit 1) and bank_out to O (bit 0).
- R7: A command byte 11111_ABB sets blink_alt to A (bit 2) and blink_freq to BB (bits 1:0).
- R8: Command bytes 1101_xxxx and 11101_xxx are consumed but change no output register.
- R9: A display byte offered while subaddress counter = hw_subaddr raises ram_wvalid, with ram_waddr = data pointer and ram_wdata = the byte. When the two differ, no write is requested.
- R10: Each consumed display byte advances the data pointer by one, whether or not it matched. From RAM_DEPTH-1 (39 by default) the pointer wraps to 0 and the subaddress counter increments.
- R11: While a transfer is open, ack_en is high for any offered command byte. For an offered display byte it is high only when the subaddress counter equals hw_subaddr.
- R12: Bytes offered outside a START..STOP transfer are consumed (rx_ready high), are not acknowledged and change nothing. A later START restores normal decoding.
- R13: While a matching display byte waits with ram_wready low, rx_ready is low and the data pointer holds. The byte is consumed on the first cycle with ram_wready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_subaddr | input | 3 | Hardware subaddress pins |
| bus_start | input | 1 | START or repeated START seen on the bus |
| bus_stop | input | 1 | STOP seen on the bus |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Decoder accepts the byte |
| rx_data | input | 8 | Received byte |
| rx_is_cmd | input | 1 | 1 = command byte, 0 = display byte |
| ack_en | output | 1 | Acknowledge the offered byte |
| ram_wvalid | output | 1 | Display RAM write request |
| ram_wready | input | 1 | RAM port can take the write |
| ram_waddr | output | 7 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |
| disp_en | output | 1 | Display enabled |
| bias_sel | output | 1 | Stored bias select bit |
| bias_eff | output | 1 | Bias select as applied (0 in static mode) |
| drive_mode | output | 2 | Stored drive mode code |
| mux_ways | output | 3 | Number of backplanes driven |
| data_ptr | output | 7 | Display data pointer |
| subaddr_cnt | output | 3 | Subaddress counter |
| bank_in | output | 1 | Input RAM bank |
| bank_out | output | 1 | Output RAM bank |
| blink_alt | output | 1 | Alternate-bank blink |
| blink_freq | output | 2 | Blink frequency code |

## Verification
The mode-set decode is tried with a table of command bytes that steps the bias bit through every drive mode, with an unassigned opcode placed in the middle of the table. This separates field extraction from the static-mode bias override, and shows that an unknown code leaves every field alone. Display bytes are sent with the subaddress matching and not matching, and with the pointer just below and at the wrap point. These show that writing and acknowledgement are gated by the match, while pointer advance is not, and that the subaddress carry happens exactly at the last address. A stalled RAM port and bytes sent after STOP show the difference between a byte that is held and a byte that is drained without effect.

// File: rtl/lcdcd_pkg.sv
package lcdcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MODE,
    OP_PTR,
    OP_DEV,
    OP_BANK,
    OP_BLINK
  } op_e;

  typedef struct packed {
    logic       disp_en;
    logic       bias_sel;
    logic [1:0] drive_mode;
    logic       bank_in;
    logic       bank_out;
    logic       blink_alt;
    logic [1:0] blink_freq;
  } cfg_t;

  localparam logic [1:0] DRV_STATIC = 2'b01;
  localparam logic [1:0] DRV_QUAD   = 2'b00;

  // Prefix decode: the shortest matching prefix wins, and every
  // byte maps to exactly one class.
  function automatic op_e classify(input logic [7:0] b);
    op_e r;
    if (!b[7])                   r = OP_PTR;
    else if (b[7:4] == 4'b1100)  r = OP_MODE;
    else if (b[7:3] == 5'b11100) r = OP_DEV;
    else if (b[7:3] == 5'b11110) r = OP_BANK;
    else if (b[7:3] == 5'b11111) r = OP_BLINK;
    else                         r = OP_NONE;
    return r;
  endfunction

endpackage

// File: rtl/lcdcd_cmd_decode.sv
module lcdcd_cmd_decode
  import lcdcd_pkg::*;
(
  input  logic [7:0] byte_in,
  output op_e        op
);
  always_comb op = classify(byte_in);
endmodule

// File: rtl/lcdcd_cfg_regs.sv
module lcdcd_cfg_regs
  import lcdcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_fire,
  input  op_e        op,
  input  logic [3:0] arg,
  output cfg_t       cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg            <= '0;
      cfg.drive_mode <= DRV_QUAD;
    end else if (cmd_fire) begin
      unique case (op)
        OP_MODE: begin
          cfg.disp_en    <= arg[3];
          cfg.bias_sel   <= arg[2];
          cfg.drive_mode <= arg[1:0];
        end
        OP_BANK: begin
          cfg.bank_in  <= arg[1];
          cfg.bank_out <= arg[0];
        end
        OP_BLINK: begin
          cfg.blink_alt  <= arg[2];
          cfg.blink_freq <= arg[1:0];
        end
        default: ;
      endcase
    end
  end

  assert_unknown_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_NONE) |=> $stable(cfg));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op == OP_MODE) |=>
      (cfg.disp_en == $past(arg[3]) && cfg.drive_mode == $past(arg[1:0])));

endmodule

// File: rtl/lcdcd_addr_ctr.sv
module lcdcd_addr_ctr #(
  parameter int PTR_W     = 7,
  parameter int SUB_W     = 3,
  parameter int RAM_DEPTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             sub_load,
  input  logic [SUB_W-1:0] sub_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic [SUB_W-1:0] sub
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

  logic at_end;
  assign at_end = (ptr >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      sub <= '0;
    end else begin
      if (ptr_load)    ptr <= ptr_val;
      else if (step)   ptr <= at_end ? '0 : ptr + PTR_W'(1);
      if (sub_load)           sub <= sub_val;
      else if (step && at_end) sub <= sub + SUB_W'(1);
    end
  end

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ptr_load && !sub_load && ptr < LAST) |=>
      (ptr == $past(ptr) + PTR_W'(1) && $stable(sub)));

  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ptr_load && !sub_load && ptr == LAST) |=>
      (ptr == '0 && sub == $past(sub) + SUB_W'(1)));

endmodule

// File: rtl/lcdcd_top.sv
module lcdcd_top
  import lcdcd_pkg::*;
#(
  parameter int PTR_W     = 7,
  parameter int SUB_W     = 3,
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  hw_subaddr,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_is_cmd,
  output logic              ack_en,
  output logic              ram_wvalid,
  input  logic              ram_wready,
  output logic [PTR_W-1:0]  ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              disp_en,
  output logic              bias_sel,
  output logic              bias_eff,
  output logic [1:0]        drive_mode,
  output logic [2:0]        mux_ways,
  output logic [PTR_W-1:0]  data_ptr,
  output logic [SUB_W-1:0]  subaddr_cnt,
  output logic              bank_in,
  output logic              bank_out,
  output logic              blink_alt,
  output logic [1:0]        blink_freq
);

  logic xfer_open;
  logic sub_match;
  logic fire;
  logic cmd_fire;
  logic disp_fire;
  op_e  op;
  cfg_t cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         xfer_open <= 1'b0;
    else if (bus_start) xfer_open <= 1'b1;
    else if (bus_stop)  xfer_open <= 1'b0;
  end

  assign sub_match  = (subaddr_cnt == hw_subaddr);
  assign rx_ready   = !xfer_open || rx_is_cmd || !sub_match || ram_wready;
  assign ram_wvalid = rx_valid && xfer_open && !rx_is_cmd && sub_match;
  assign ack_en     = rx_valid && xfer_open && (rx_is_cmd || sub_match);
  assign fire       = rx_valid && rx_ready && xfer_open;
  assign cmd_fire   = fire && rx_is_cmd;
  assign disp_fire  = fire && !rx_is_cmd;
  assign ram_waddr  = data_ptr;
  assign ram_wdata  = rx_data;

  lcdcd_cmd_decode u_dec (
    .byte_in (rx_data[7:0]),
    .op      (op)
  );

  lcdcd_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (cmd_fire),
    .op       (op),
    .arg      (rx_data[3:0]),
    .cfg      (cfg)
  );

  lcdcd_addr_ctr #(
    .PTR_W     (PTR_W),
    .SUB_W     (SUB_W),
    .RAM_DEPTH (RAM_DEPTH)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (cmd_fire && op == OP_PTR),
    .ptr_val  (rx_data[PTR_W-1:0]),
    .sub_load (cmd_fire && op == OP_DEV),
    .sub_val  (rx_data[SUB_W-1:0]),
    .step     (disp_fire),
    .ptr      (data_ptr),
    .sub      (subaddr_cnt)
  );

  assign disp_en    = cfg.disp_en;
  assign bias_sel   = cfg.bias_sel;
  assign drive_mode = cfg.drive_mode;
  assign bias_eff   = cfg.bias_sel && (cfg.drive_mode != DRV_STATIC);
  assign mux_ways   = (cfg.drive_mode == DRV_QUAD) ? 3'd4 : {1'b0, cfg.drive_mode};
  assign bank_in    = cfg.bank_in;
  assign bank_out   = cfg.bank_out;
  assign blink_alt  = cfg.blink_alt;
  assign blink_freq = cfg.blink_freq;

  assert_static_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_ways == 3'd1) |-> !bias_eff);

  assert_write_acked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wvalid |-> ack_en);

  assert_closed_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_open |-> (!ack_en && !ram_wvalid && rx_ready));

  assert_stall_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> $stable(data_ptr));

endmodule

// File: tb/lcdcd_top_tb_top.sv
module lcdcd_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hw_subaddr = 3'd2;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       rx_valid = 1'b0, rx_is_cmd = 1'b0, ram_wready = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, ack_en, ram_wvalid;
  logic [6:0] ram_waddr, data_ptr;
  logic [7:0] ram_wdata;
  logic       disp_en, bias_sel, bias_eff, bank_in, bank_out, blink_alt;
  logic [1:0] drive_mode, blink_freq;
  logic [2:0] mux_ways, subaddr_cnt;

  int nchk = 0, nfail = 0;
  logic s_ack, s_wv, s_rdy;
  logic [6:0] s_wa;
  logic [7:0] s_wd;
  logic [19:0] snap;

  always #10 clk = ~clk;

  lcdcd_top dut_i (
    .clk(clk), .rst_n(rst_n), .hw_subaddr(hw_subaddr),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_is_cmd(rx_is_cmd), .ack_en(ack_en),
    .ram_wvalid(ram_wvalid), .ram_wready(ram_wready),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .disp_en(disp_en), .bias_sel(bias_sel), .bias_eff(bias_eff),
    .drive_mode(drive_mode), .mux_ways(mux_ways),
    .data_ptr(data_ptr), .subaddr_cnt(subaddr_cnt),
    .bank_in(bank_in), .bank_out(bank_out),
    .blink_alt(blink_alt), .blink_freq(blink_freq)
  );

  // {byte, en, bias, mode, ways, bias_eff}
  localparam logic [15:0] VEC [8] = '{
    {8'hC8, 1'b1, 1'b0, 2'b00, 3'd4, 1'b0},
    {8'hCD, 1'b1, 1'b1, 2'b01, 3'd1, 1'b0},
    {8'hCE, 1'b1, 1'b1, 2'b10, 3'd2, 1'b1},
    {8'hC3, 1'b0, 1'b0, 2'b11, 3'd3, 1'b0},
    {8'hC7, 1'b0, 1'b1, 2'b11, 3'd3, 1'b1},
    {8'hD5, 1'b0, 1'b1, 2'b11, 3'd3, 1'b1},
    {8'hCC, 1'b1, 1'b1, 2'b00, 3'd4, 1'b1},
    {8'hC5, 1'b0, 1'b1, 2'b01, 3'd1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_is_cmd = is_cmd; rx_data = b;
    #1;
    s_ack = ack_en; s_wv = ram_wvalid; s_wa = ram_waddr; s_wd = ram_wdata; s_rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  function automatic logic [19:0] state_now();
    return {disp_en, bias_sel, drive_mode, bank_in, bank_out, blink_alt,
            blink_freq, data_ptr, subaddr_cnt};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 disp_en", disp_en, 0);
    chk("R1 bias", {bias_sel, bias_eff}, 0);
    chk("R1 mode", drive_mode, 2'b00);
    chk("R1 ways", mux_ways, 4);
    chk("R1 ptr/sub", {data_ptr, subaddr_cnt}, 0);
    chk("R1 bank/blink", {bank_in, bank_out, blink_alt, blink_freq}, 0);

    pulse_start();

    for (int i = 0; i < 8; i++) begin
      send(1'b1, VEC[i][15:8]);
      chk("R2 disp_en", disp_en, VEC[i][7]);
      chk("R2 bias_sel", bias_sel, VEC[i][6]);
      chk("R2 drive_mode", drive_mode, VEC[i][5:4]);
      chk("R2 mux_ways", mux_ways, VEC[i][3:1]);
      chk("R3 bias_eff", bias_eff, VEC[i][0]);
    end

    send(1'b1, 8'h25); chk("R4 ptr", data_ptr, 7'h25);
    send(1'b1, 8'h00); chk("R4 ptr zero", data_ptr, 7'h00);
    send(1'b1, 8'hE5); chk("R5 sub", subaddr_cnt, 5);
    send(1'b1, 8'hF2); chk("R6 banks", {bank_in, bank_out}, 2'b10);
    send(1'b1, 8'hF1); chk("R6 banks", {bank_in, bank_out}, 2'b01);
    send(1'b1, 8'hFE); chk("R7 blink", {blink_alt, blink_freq}, 3'b110);
    send(1'b1, 8'hF9); chk("R7 blink", {blink_alt, blink_freq}, 3'b001);

    snap = state_now();
    send(1'b1, 8'hEB); chk("R8 11101 code", state_now(), snap);
    send(1'b1, 8'hD0); chk("R8 1101 code", state_now(), snap);

    // matched display byte
    send(1'b1, 8'hE2);
    send(1'b1, 8'h10);
    send(1'b0, 8'hA5);
    chk("R9 wvalid", s_wv, 1);
    chk("R9 waddr", s_wa, 7'h10);
    chk("R9 wdata", s_wd, 8'hA5);
    chk("R11 ack matched", s_ack, 1);
    chk("R10 step", data_ptr, 7'h11);

    // mismatched subaddress
    send(1'b1, 8'hE3);
    chk("R11 cmd ack mismatched", s_ack, 1);
    send(1'b0, 8'h5A);
    chk("R9 no write", s_wv, 0);
    chk("R11 no ack", s_ack, 0);
    chk("R9 ready", s_rdy, 1);
    chk("R10 step mismatched", {data_ptr, subaddr_cnt}, {7'h12, 3'd3});

    // wrap
    send(1'b1, 8'hE1);
    send(1'b1, 8'h26);
    send(1'b0, 8'h11);
    chk("R10 to last", {data_ptr, subaddr_cnt}, {7'd39, 3'd1});
    send(1'b0, 8'h22);
    chk("R10 wrap", {data_ptr, subaddr_cnt}, {7'd0, 3'd2});
    send(1'b0, 8'h33);
    chk("R9 after wrap", {s_wv, s_wa}, {1'b1, 7'd0});
    chk("R10 after wrap", data_ptr, 7'd1);

    // back-pressure
    @(negedge clk);
    ram_wready = 1'b0;
    rx_valid = 1'b1; rx_is_cmd = 1'b0; rx_data = 8'h44;
    #1;
    chk("R13 ready low", rx_ready, 0);
    chk("R13 wvalid", ram_wvalid, 1);
    repeat (2) @(negedge clk);
    chk("R13 ptr held", data_ptr, 7'd1);
    ram_wready = 1'b1;
    #1;
    chk("R13 ready high", rx_ready, 1);
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R13 consumed", data_ptr, 7'd2);

    // closed transfer
    pulse_stop();
    send(1'b1, 8'h30);
    chk("R12 no ack", s_ack, 0);
    chk("R12 ready", s_rdy, 1);
    chk("R12 ptr", data_ptr, 7'd2);
    send(1'b0, 8'h55);
    chk("R12 no write", s_wv, 0);
    chk("R12 ptr display", data_ptr, 7'd2);
    pulse_start();
    send(1'b1, 8'h30);
    chk("R12 restarted", data_ptr, 7'h30);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule